// File: doc/BRIEF.md
# ATM Cell Transmit Formatter

This block sits between a queue of outgoing 53-byte ATM cells and a serial line interface. Each time the line asks for a cell, the block sends one complete cell as a gap-free byte stream. The cell comes from the queue when the queue holds a complete cell. Otherwise the block sends a substitute cell taken from a small template store.

On the way out, the block computes the header error check byte over the first four header bytes. It can add a fixed coset value to that byte. It then writes the result into header byte 4, replacing whatever was there. The 48 payload bytes pass through a self-synchronizing x^43+1 scrambler, which can be turned off.

The configuration pins choose three things: which substitute cell is sent (idle or filler), whether the coset is added, and whether the payload is scrambled. A write port lets the substitute templates be overwritten. A one-cycle control pulse restores all templates to their defaults.

Top module: `atm_tc_formatter`

## Requirements
- R1: Byte 4 of every sent cell is the CRC-8 of bytes 0..3. The generator is x^8+x^2+x+1, the register starts at zero and bits are taken MSB first. The result is XORed with 0x55 when `cfg_coset_off`=0 and left as is when `cfg_coset_off`=1.
- R2: Bytes 0..3 of a sent cell equal the source header bytes unchanged. The source byte 4 (queued or template) never reaches the line.
- R3: With `cfg_scr_off`=0, each payload bit (bytes 5..52, MSB first) is sent as the source bit XOR the line bit sent 43 payload bits earlier. That history is all zero after reset and carries over from one cell to the next.
- R4: With `cfg_scr_off`=1, payload bytes are sent unchanged and the scrambler history does not advance.
- R5: If `q_avail`=0 when a request is accepted, a substitute cell is sent. With `cfg_ima`=0 it is the idle cell: header 00 00 00 01, payload all 0x6A. With `cfg_ima`=1 it is the filler cell: header 00 00 00 0B, payload all 0x6A.
- R6: Each accepted request yields exactly 53 consecutive cycles of `tx_valid`. `tx_soc` is high on the first of them only. The first byte appears after the second rising edge that sees `line_req` high while the block is idle.
- R7: `line_req` is ignored while a cell is being sent. No extra cell follows.
- R8: For a queued cell, `q_rd` is high for exactly 53 cycles and the bytes are used in order. `q_rd` stays low while a substitute cell is sent.
- R9: A write through `tmpl_we` (`tmpl_sel` 0 = idle, 1 = filler; `tmpl_idx` = byte 0..52) changes later substitute cells. `tmpl_reinit` restores the defaults of R5.
- R10: After reset, `tx_valid`, `tx_soc` and `q_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_avail | input | 1 | Queue holds a complete cell |
| q_soc | input | 1 | Queue head byte is byte 0 of a cell |
| q_data | input | 8 | Queue head byte (shown before read) |
| q_rd | output | 1 | Pop one byte from the queue |
| line_req | input | 1 | Line requests one cell |
| tx_valid | output | 1 | Output byte valid |
| tx_soc | output | 1 | Output byte is byte 0 of a cell |
| tx_data | output | 8 | Output byte |
| cfg_ima | input | 1 | 1: filler substitute, 0: idle substitute |
| cfg_coset_off | input | 1 | 1: no coset added to the check byte |
| cfg_scr_off | input | 1 | 1: payload scrambling disabled |
| tmpl_we | input | 1 | Template byte write strobe |
| tmpl_sel | input | 1 | Template select (0 idle, 1 filler) |
| tmpl_idx | input | 6 | Template byte index |
| tmpl_wdata | input | 8 | Template write data |
| tmpl_reinit | input | 1 | Restore template defaults |

## Verification
If the CRC register is not cleared between cells, the error shows at byte 4 of the very next cell, five cycles into it. If the scrambler history is corrupted, the descrambled payload goes wrong within the next 43 payload bits. Because the scrambler is self-synchronizing, the damage clears itself after that. The bench therefore descrambles from the line bits it has received, keeping a history that runs across all cells. A byte counter that is off by one shows up at once, as a wrong `tx_valid` length or a `q_rd` count other than 53 for that same cell.

// File: rtl/atm_tc_pkg.sv
package atm_tc_pkg;
  localparam int SCR_LEN  = 43;
  localparam int CELL_LEN = 53;
  localparam int HDR_LEN  = 4;

  typedef struct packed {
    logic [SCR_LEN-1:0] st;
    logic [7:0]         d;
  } scr_res_t;

  // CRC-8, generator x^8+x^2+x+1, one byte MSB first
  function automatic logic [7:0] hec_step(input logic [7:0] crc, input logic [7:0] b);
    logic [7:0] c;
    c = crc ^ b;
    for (int i = 0; i < 8; i++)
      c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    return c;
  endfunction

  // self-synchronizing x^43+1 scrambling of one byte, MSB first
  function automatic scr_res_t scr_byte(input logic [SCR_LEN-1:0] st, input logic [7:0] b);
    scr_res_t r;
    logic o;
    r.st = st;
    r.d  = '0;
    for (int i = 7; i >= 0; i--) begin
      o      = b[i] ^ r.st[SCR_LEN-1];
      r.d[i] = o;
      r.st   = {r.st[SCR_LEN-2:0], o};
    end
    return r;
  endfunction

  // default substitute cell content: sel 0 idle, sel 1 filler
  function automatic logic [7:0] tmpl_default(input logic sel, input int idx);
    if (idx == 3)      return sel ? 8'h0B : 8'h01;
    else if (idx < 5)  return 8'h00;
    else               return 8'h6A;
  endfunction
endpackage

// File: rtl/atm_tc_hec.sv
module atm_tc_hec
  import atm_tc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc <= '0;
    else if (en)       crc <= hec_step(crc, din);
  end

  p_hec_cleared_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == 8'h00));
endmodule

// File: rtl/atm_tc_scrambler.sv
module atm_tc_scrambler
  import atm_tc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic [7:0] din,
  output logic [7:0] dout
);
  logic [SCR_LEN-1:0] state;
  scr_res_t           res;

  always_comb res = scr_byte(state, din);
  assign dout = res.d;

  always_ff @(posedge clk) begin
    if (!rst_n)   state <= '0;
    else if (adv) state <= res.st;
  end

  p_scr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state));
endmodule

// File: rtl/atm_tc_tmpl.sv
module atm_tc_tmpl
  import atm_tc_pkg::*;
#(
  parameter int IDXW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reinit,
  input  logic            we,
  input  logic            wsel,
  input  logic [IDXW-1:0] widx,
  input  logic [7:0]      wdata,
  input  logic            rsel,
  input  logic [IDXW-1:0] ridx,
  output logic [7:0]      rdata
);
  logic [7:0] mem [2][CELL_LEN];

  for (genvar s = 0; s < 2; s++) begin : g_sel
    for (genvar i = 0; i < CELL_LEN; i++) begin : g_byte
      always_ff @(posedge clk) begin
        if (!rst_n || reinit)
          mem[s][i] <= tmpl_default(s[0], i);
        else if (we && wsel == s[0] && widx == IDXW'(i))
          mem[s][i] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (ridx < IDXW'(CELL_LEN)) rdata = mem[rsel][ridx];
  end

  p_reinit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> (mem[1][3] == 8'h0B && mem[0][3] == 8'h01));
endmodule

// File: rtl/atm_tc_formatter.sv
module atm_tc_formatter
  import atm_tc_pkg::*;
#(
  parameter logic [7:0] COSET = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       q_avail,
  input  logic       q_soc,
  input  logic [7:0] q_data,
  output logic       q_rd,
  input  logic       line_req,
  output logic       tx_valid,
  output logic       tx_soc,
  output logic [7:0] tx_data,
  input  logic       cfg_ima,
  input  logic       cfg_coset_off,
  input  logic       cfg_scr_off,
  input  logic       tmpl_we,
  input  logic       tmpl_sel,
  input  logic [5:0] tmpl_idx,
  input  logic [7:0] tmpl_wdata,
  input  logic       tmpl_reinit
);
  localparam int IDXW = $clog2(CELL_LEN);
  localparam logic [IDXW-1:0] LAST = IDXW'(CELL_LEN - 1);
  localparam logic [IDXW-1:0] HEC_AT = IDXW'(HDR_LEN);

  logic            busy, use_q;
  logic [IDXW-1:0] idx;
  logic            accept, last_byte, in_hdr, in_hec, in_pay;
  logic [7:0]      src_byte, tmpl_byte, crc, scr_out, out_byte;

  assign accept    = line_req && !busy;
  assign last_byte = busy && idx == LAST;
  assign in_hdr    = busy && idx < HEC_AT;
  assign in_hec    = busy && idx == HEC_AT;
  assign in_pay    = busy && idx > HEC_AT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      use_q <= 1'b0;
    end else if (accept) begin
      busy  <= 1'b1;
      idx   <= '0;
      use_q <= q_avail;
    end else if (busy) begin
      busy <= !last_byte;
      idx  <= last_byte ? '0 : idx + 1'b1;
    end
  end

  assign q_rd     = busy && use_q;
  assign src_byte = use_q ? q_data : tmpl_byte;

  atm_tc_tmpl #(.IDXW(IDXW)) u_tmpl (
    .clk(clk), .rst_n(rst_n), .reinit(tmpl_reinit),
    .we(tmpl_we), .wsel(tmpl_sel), .widx(IDXW'(tmpl_idx)), .wdata(tmpl_wdata),
    .rsel(cfg_ima), .ridx(idx), .rdata(tmpl_byte)
  );

  atm_tc_hec u_hec (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(in_hdr),
    .din(src_byte), .crc(crc)
  );

  atm_tc_scrambler u_scr (
    .clk(clk), .rst_n(rst_n), .adv(in_pay && !cfg_scr_off),
    .din(src_byte), .dout(scr_out)
  );

  always_comb begin
    if (in_hec)                    out_byte = crc ^ (cfg_coset_off ? 8'h00 : COSET);
    else if (in_pay && !cfg_scr_off) out_byte = scr_out;
    else                           out_byte = src_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_soc   <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= busy;
      tx_soc   <= busy && idx == '0;
      tx_data  <= out_byte;
    end
  end

  p_soc_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_soc |-> tx_valid);
  p_gapless_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> tx_valid);
  p_req_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_byte) |=> (busy && $stable(use_q)));
  p_qrd_user_r8: assert property (@(posedge clk) disable iff (!rst_n)
    q_rd |-> (busy && use_q));
  p_q_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (q_rd && idx == '0) |-> q_soc);
endmodule

// File: tb/tb_atm_tc_formatter.sv
module tb_atm_tc_formatter;
  localparam int CLK_NS = 10;
  localparam int NV = 7;
  // {use_queue, ima, coset_off, scr_off, seed}
  localparam logic [11:0] VEC [NV] = '{
    {4'b1000, 8'h10}, {4'b1010, 8'h80}, {4'b0000, 8'h00}, {4'b0100, 8'h00},
    {4'b1001, 8'h33}, {4'b0110, 8'h00}, {4'b1100, 8'hF0}
  };

  logic clk = 0, rst_n = 0;
  logic q_avail = 0, line_req = 0, cfg_ima = 0, cfg_coset_off = 0, cfg_scr_off = 0;
  logic tmpl_we = 0, tmpl_sel = 0, tmpl_reinit = 0;
  logic [5:0] tmpl_idx = 0;
  logic [7:0] tmpl_wdata = 0, seed = 0;
  logic q_rd, q_soc, tx_valid, tx_soc;
  logic [7:0] q_data, tx_data;
  int qidx = 0, nrd = 0, tests = 0, fails = 0;
  logic [42:0] hist = '0;
  logic [7:0] pay_over [53];
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [7:0] ubyte(input logic [7:0] s, input int i);
    return (i < 4) ? s + 8'(i) : (s ^ 8'(i * 7));
  endfunction

  assign q_data = ubyte(seed, qidx);
  assign q_soc  = (qidx == 0);
  always @(posedge clk) if (q_rd) begin qidx <= qidx + 1; nrd <= nrd + 1; end

  atm_tc_formatter dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s act=%0h exp=%0h", req, act, exp); end
  endtask

  // bit-serial CRC division, register starts at zero
  function automatic logic [7:0] ref_hec(input logic [31:0] h);
    logic [7:0] r = 0; logic fb;
    for (int k = 31; k >= 0; k--) begin fb = r[7] ^ h[k]; r = {r[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00); end
    return r;
  endfunction

  task automatic send(input bit uq, input bit ima, input bit coff, input bit soff,
                      input logic [7:0] sd, input bit poke, input bit use_over);
    logic [7:0] exp_b [53];
    logic [7:0] rx, d;
    @(negedge clk);
    q_avail = uq; cfg_ima = ima; cfg_coset_off = coff; cfg_scr_off = soff; seed = sd;
    qidx = 0; nrd = 0;
    for (int i = 0; i < 53; i++)
      exp_b[i] = uq ? ubyte(sd, i) : use_over ? pay_over[i] : ((i == 3) ? (ima ? 8'h0B : 8'h01) : (i < 5 ? 8'h00 : 8'h6A));
    exp_b[4] = ref_hec({exp_b[0], exp_b[1], exp_b[2], exp_b[3]}) ^ (coff ? 8'h00 : 8'h55);
    line_req = 1;
    @(negedge clk); line_req = 0;
    chk(!tx_valid, "R6 no output before second edge", tx_valid, 0);
    for (int b = 0; b < 53; b++) begin
      @(negedge clk);
      line_req = poke && (b == 20);
      chk(tx_valid, "R6 valid run", tx_valid, 1);
      chk(tx_soc == (b == 0), "R6 soc", tx_soc, b == 0);
      rx = tx_data;
      if (b >= 5 && !soff) begin
        for (int k = 7; k >= 0; k--) begin d[k] = rx[k] ^ hist[42]; hist = {hist[41:0], rx[k]}; end
        chk(d == exp_b[b], "R3 descrambled payload", d, exp_b[b]);
      end else if (b == 4) chk(rx == exp_b[4], "R1 R2 check byte", rx, exp_b[4]);
      else if (b < 4) chk(rx == exp_b[b], "R2 header", rx, exp_b[b]);
      else chk(rx == exp_b[b], "R4 plain payload", rx, exp_b[b]);
    end
    line_req = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!tx_valid, "R6 R7 no extra bytes", tx_valid, 0);
    end
    chk(nrd == (uq ? 53 : 0), "R8 queue reads", nrd, uq ? 53 : 0);
  endtask

  initial begin
    for (int i = 0; i < 53; i++) pay_over[i] = (i == 3) ? 8'h01 : (i < 5 ? 8'h00 : 8'h6A);
    repeat (3) @(negedge clk);
    chk(!tx_valid && !tx_soc && !q_rd, "R10 reset outputs", {tx_valid, tx_soc, q_rd}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!tx_valid && !q_rd, "R10 idle after reset", {tx_valid, q_rd}, 0);
    // R1 R2 R3 R4 R5 R6 R8: vector table
    for (int v = 0; v < NV; v++)
      send(VEC[v][11], VEC[v][10], VEC[v][9], VEC[v][8], VEC[v][7:0], 0, 0);
    // R7: request during a cell
    send(1, 0, 0, 0, 8'h55, 1, 0);
    // R9: template writes, including the check byte slot
    @(negedge clk);
    tmpl_we = 1; tmpl_sel = 0; tmpl_idx = 10; tmpl_wdata = 8'hAA;
    @(negedge clk); tmpl_idx = 4; tmpl_wdata = 8'hFF;
    @(negedge clk); tmpl_idx = 2; tmpl_wdata = 8'h3C;
    @(negedge clk); tmpl_we = 0;
    pay_over[10] = 8'hAA; pay_over[2] = 8'h3C;
    send(0, 0, 0, 0, 8'h00, 0, 1);
    send(0, 0, 1, 1, 8'h00, 0, 1);
    // R9: restore defaults
    @(negedge clk); tmpl_reinit = 1;
    @(negedge clk); tmpl_reinit = 0;
    send(0, 0, 0, 0, 8'h00, 0, 0);
    send(0, 1, 0, 0, 8'h00, 0, 0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule